// File: doc/BRIEF.md
# Real-Time-Clock Oscillator Prescaler

This block is the time base of a real-time clock. It runs on the oscillator clock. It divides that clock through a binary divide chain down to a once-per-second update strobe. A 3-bit divider-select code chooses how many of the first chain stages are skipped, so that one chain can serve several oscillator frequencies. The code can also stop the chain and hold it cleared. The count held in every chain stage is brought out as a tap vector, which periodic-rate logic elsewhere can decode.

The divider-select code comes from another clock domain. A flop synchronizer brings it into the oscillator domain before it has any effect. A control state machine has three states. ST_HOLD keeps the chain cleared. ST_ARM clears the chain and latches the new skip count. ST_RUN advances the chain. Its transitions are:

- hold-to-arm: a running code appears.
- arm-to-run: the code stays the same for one more cycle.
- arm-to-arm and run-to-arm (re-arm): a running code with a different skip count appears.
- arm-to-hold and run-to-hold (park): a non-running code appears.
- run-to-run (advance): otherwise.

Every restart begins from zero, so the first strobe comes half a period after the chain starts.

A parameter selects a reduced crystal-only variant with a shorter chain. In that variant the lowest code bit alone decides whether the chain runs, and it always runs with no stages skipped.

Top module: `rtc_prescaler`

## Requirements
- R1: While reset is asserted and directly after it, `tick_1hz` is 0 and `stage_taps` is all zeros. The synchronizer resets to the code 111, which is a non-running code in both variants.
- R2: In the full variant, code 000 skips no stages. After the first strobe, `tick_1hz` pulses once every 2^CHAIN_LEN cycles.
- R3: In the full variant, code 001 skips the first SKIP_MID stages. The strobe period is 2^(CHAIN_LEN-SKIP_MID) cycles.
- R4: In the full variant, code 010 skips the first SKIP_XTAL stages. The strobe period is 2^(CHAIN_LEN-SKIP_XTAL) cycles, which is 1 Hz from 32.768 kHz with the default parameters.
- R5: In the full variant, codes 110 and 111 park the chain. No strobe is produced, and `stage_taps` reads zero from the third clock edge after the code is applied.
- R6: In the full variant, codes 011, 100 and 101 behave exactly like codes 110 and 111: no strobe, and the taps stay at zero.
- R7: In the crystal-only variant, any code whose bit 0 is 0 runs a chain of XTAL_LEN stages. The strobe period is 2^XTAL_LEN cycles, whatever bits 2:1 hold, and a change in bits 2:1 alone does not restart the chain.
- R8: In the crystal-only variant, any code whose bit 0 is 1 parks the chain: no strobe, and the taps stay at zero.
- R9: A chain that starts from a parked state, with chain length L = stages minus stages skipped, raises its first strobe at clock edge 4+2^(L-1). Edges are counted from the first edge after the code is applied. This is half a period after the chain starts.
- R10: `tick_1hz` is high for exactly one clock cycle per strobe. It rises in the cycle in which the top tap bit goes from 0 to 1.
- R11: A new code takes effect at the third clock edge after it is applied. On the first two edges the chain keeps its previous behaviour.
- R12: A change between two running codes with different skip counts clears the chain and restarts it with the new skip count. The first strobe then comes at edge 4+2^(L-1), with L taken from the new code.
- R13: `stage_taps` holds the chain count. While the chain runs, it advances by 2^skip each cycle, and tap bits below the skip count stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock. Each cycle is one input period. |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_code | input | 3 | Divider-select code. It may come from another clock domain. |
| tick_1hz | output | 1 | Single-cycle update strobe |
| stage_taps | output | CRYSTAL_ONLY ? XTAL_LEN : CHAIN_LEN | Current count of the divide chain, with bit k being stage k |

## Verification
The bench drives the three running codes in turn on the full variant. It measures both the first-strobe delay and the steady period, which tells apart the skip counts and shows that a change between running codes restarts from zero. It then applies the five non-running codes to show they are all equivalent to parking. The bench also watches the taps across the two synchronizer edges, to separate the moment a code takes effect from a design that reacts early or late. The crystal-only variant is run with codes that differ only in bits 2:1 and codes that differ in bit 0. This shows that only bit 0 matters and that the upper bits do not restart the chain.

// File: rtl/rtc_div_pkg.sv
package rtc_div_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } div_state_e;

    // Reset value of the synchronizer: a non-running code in both variants
    localparam logic [2:0] CODE_PARK = 3'b111;

endpackage

// File: rtl/rtc_code_sync.sv
module rtc_code_sync #(
    parameter int          W       = 3,
    parameter int          DEPTH   = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] pipe [DEPTH];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[g] <= RST_VAL;
                    else        pipe[g] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[g] <= RST_VAL;
                    else        pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    assign q_sync = pipe[DEPTH-1];

endmodule

// File: rtl/rtc_div_decode.sv
module rtc_div_decode #(
    parameter int CRYSTAL_ONLY = 0,
    parameter int BPW          = 4,
    parameter int SKIP_MID     = 2,
    parameter int SKIP_XTAL    = 7
) (
    input  logic [2:0]     code,
    output logic           run_ok,
    output logic [BPW-1:0] bypass
);

    generate
        if (CRYSTAL_ONLY != 0) begin : g_xtal
            // Bit 0 gates the chain; no stages skipped
            always_comb begin
                run_ok = ~code[0];
                bypass = '0;
            end
        end else begin : g_full
            always_comb begin
                run_ok = 1'b0;
                bypass = '0;
                unique case (code)
                    3'b000: begin run_ok = 1'b1; bypass = '0; end
                    3'b001: begin run_ok = 1'b1; bypass = BPW'(SKIP_MID); end
                    3'b010: begin run_ok = 1'b1; bypass = BPW'(SKIP_XTAL); end
                    default: begin run_ok = 1'b0; bypass = '0; end
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/rtc_div_fsm.sv
module rtc_div_fsm
    import rtc_div_pkg::*;
#(
    parameter int BPW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run_ok,
    input  logic [BPW-1:0] bypass_req,
    output logic [BPW-1:0] bypass_cur,
    output logic           advance,
    output logic           clear
);

    div_state_e state, nxt;

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_HOLD: nxt = run_ok ? ST_ARM : ST_HOLD;
            ST_ARM: begin
                if (!run_ok)                         nxt = ST_HOLD;
                else if (bypass_req != bypass_cur)   nxt = ST_ARM;
                else                                 nxt = ST_RUN;
            end
            ST_RUN: begin
                if (!run_ok)                         nxt = ST_HOLD;
                else if (bypass_req != bypass_cur)   nxt = ST_ARM;
                else                                 nxt = ST_RUN;
            end
            default: nxt = ST_HOLD;
        endcase
    end

    // state register and latched skip count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_HOLD;
            bypass_cur <= '0;
        end else begin
            state <= nxt;
            if (nxt == ST_ARM) bypass_cur <= bypass_req;
        end
    end

    // outputs to the chain
    always_comb begin
        advance = (state == ST_RUN) && (nxt == ST_RUN);
        clear   = ~advance;
    end

    // R9: the chain never runs without passing through the arm state
    p_no_skip_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> ($past(state) != ST_HOLD));

    // R5: a non-running code always parks at the next edge
    p_park_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_ok |=> (state == ST_HOLD));

endmodule

// File: rtl/rtc_div_chain.sv
module rtc_div_chain #(
    parameter int LEN = 22,
    parameter int BPW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           advance,
    input  logic [BPW-1:0] bypass,
    output logic [LEN-1:0] taps,
    output logic           tick
);

    logic [LEN-1:0] cnt, cnt_next, step, low_mask;

    always_comb begin
        step     = {{(LEN-1){1'b0}}, 1'b1} << bypass;
        cnt_next = cnt + step;
        low_mask = ~({LEN{1'b1}} << bypass);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (clear) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (advance) begin
            cnt  <= cnt_next;
            tick <= ~cnt[LEN-1] & cnt_next[LEN-1];
        end else begin
            tick <= 1'b0;
        end
    end

    assign taps = cnt;

    // R10: strobe lasts one cycle
    p_tick_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R10: strobe coincides with the top stage rising
    p_tick_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (taps[LEN-1] && !$past(taps[LEN-1])));

    // R13: skipped stages stay at zero while running
    p_low_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> ((cnt & low_mask) == '0));

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
    import rtc_div_pkg::*;
#(
    parameter int CRYSTAL_ONLY = 0,
    parameter int CHAIN_LEN    = 22,
    parameter int XTAL_LEN     = 15,
    parameter int SKIP_MID     = 2,
    parameter int SKIP_XTAL    = 7,
    parameter int SYNC_DEPTH   = 2
) (
    input  logic clk_osc,
    input  logic rst_n,
    input  logic [2:0] div_code,
    output logic tick_1hz,
    output logic [(CRYSTAL_ONLY != 0 ? XTAL_LEN : CHAIN_LEN)-1:0] stage_taps
);

    localparam int LEN = (CRYSTAL_ONLY != 0) ? XTAL_LEN : CHAIN_LEN;
    localparam int BPW = (LEN > 2) ? $clog2(LEN) : 1;

    logic [2:0]     code_q;
    logic           run_ok, advance, clear;
    logic [BPW-1:0] bypass_req, bypass_cur;

    rtc_code_sync #(.W(3), .DEPTH(SYNC_DEPTH), .RST_VAL(CODE_PARK)) u_sync (
        .clk     (clk_osc),
        .rst_n   (rst_n),
        .d_async (div_code),
        .q_sync  (code_q)
    );

    rtc_div_decode #(
        .CRYSTAL_ONLY (CRYSTAL_ONLY),
        .BPW          (BPW),
        .SKIP_MID     (SKIP_MID),
        .SKIP_XTAL    (SKIP_XTAL)
    ) u_dec (
        .code   (code_q),
        .run_ok (run_ok),
        .bypass (bypass_req)
    );

    rtc_div_fsm #(.BPW(BPW)) u_fsm (
        .clk        (clk_osc),
        .rst_n      (rst_n),
        .run_ok     (run_ok),
        .bypass_req (bypass_req),
        .bypass_cur (bypass_cur),
        .advance    (advance),
        .clear      (clear)
    );

    rtc_div_chain #(.LEN(LEN), .BPW(BPW)) u_chain (
        .clk     (clk_osc),
        .rst_n   (rst_n),
        .clear   (clear),
        .advance (advance),
        .bypass  (bypass_cur),
        .taps    (stage_taps),
        .tick    (tick_1hz)
    );

    // R5 / R6 / R8: a code parked for two cycles leaves the chain cleared and silent
    p_park_zero_r5: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (!run_ok && $past(!run_ok)) |-> (stage_taps == '0 && !tick_1hz));

endmodule

// File: tb/rtc_prescaler_test.sv
`timescale 1ns/1ps
module rtc_prescaler_test;

    localparam int FLEN = 12;   // full variant chain length
    localparam int XLEN = 6;    // crystal variant chain length
    localparam int SMID = 2;
    localparam int SXT  = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] code_f = 3'b111;
    logic [2:0] code_x = 3'b111;
    logic tick_f, tick_x;
    logic [FLEN-1:0] taps_f;
    logic [XLEN-1:0] taps_x;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    rtc_prescaler #(.CRYSTAL_ONLY(0), .CHAIN_LEN(FLEN), .XTAL_LEN(XLEN),
                    .SKIP_MID(SMID), .SKIP_XTAL(SXT), .SYNC_DEPTH(2)) uut (
        .clk_osc(clk), .rst_n(rst_n), .div_code(code_f),
        .tick_1hz(tick_f), .stage_taps(taps_f));

    rtc_prescaler #(.CRYSTAL_ONLY(1), .CHAIN_LEN(FLEN), .XTAL_LEN(XLEN),
                    .SKIP_MID(SMID), .SKIP_XTAL(SXT), .SYNC_DEPTH(2)) uut_x (
        .clk_osc(clk), .rst_n(rst_n), .div_code(code_x),
        .tick_1hz(tick_x), .stage_taps(taps_x));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int  m_s1 [2], m_s2 [2], m_mode [2], m_bp [2], m_cnt [2];
    bit  m_tick [2];
    int  m_len [2] = '{FLEN, XLEN};

    function automatic void m_decode(input int v, input int c, output bit ok, output int bp);
        if (v == 1) begin
            ok = (c % 2) == 0;
            bp = 0;
        end else begin
            ok = (c <= 2);
            bp = (c == 0) ? 0 : (c == 1) ? SMID : SXT;
        end
    endfunction

    always @(posedge clk) begin
        for (int v = 0; v < 2; v++) begin
            if (!rst_n) begin
                m_s1[v] = 7; m_s2[v] = 7; m_mode[v] = 0;
                m_bp[v] = 0; m_cnt[v] = 0; m_tick[v] = 0;
            end else begin
                bit ok; int bp; int mod; int nc;
                m_decode(v, m_s2[v], ok, bp);
                mod = 1 << m_len[v];
                m_tick[v] = 0;
                if (!ok) begin
                    m_mode[v] = 0; m_cnt[v] = 0;
                end else if (m_mode[v] == 0 || bp != m_bp[v]) begin
                    m_mode[v] = 1; m_bp[v] = bp; m_cnt[v] = 0;
                end else if (m_mode[v] == 1) begin
                    m_mode[v] = 2; m_cnt[v] = 0;
                end else begin
                    nc = (m_cnt[v] + (1 << m_bp[v])) % mod;
                    m_tick[v] = (m_cnt[v] < mod / 2) && (nc >= mod / 2);
                    m_cnt[v] = nc;
                end
                m_s2[v] = m_s1[v];
                m_s1[v] = (v == 0) ? int'(code_f) : int'(code_x);
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(tick_f == m_tick[0], "R13 model tick full", int'(tick_f), int'(m_tick[0]));
            chk(int'(taps_f) == m_cnt[0], "R13 model taps full", int'(taps_f), m_cnt[0]);
            chk(tick_x == m_tick[1], "R13 model tick xtal", int'(tick_x), int'(m_tick[1]));
            chk(int'(taps_x) == m_cnt[1], "R13 model taps xtal", int'(taps_x), m_cnt[1]);
        end
    end

    // ---------------- directed checks ----------------
    function automatic bit tk(input int v);
        return (v == 0) ? tick_f : tick_x;
    endfunction

    // called right after driving a running code at a negedge
    task automatic latency_chk(input int v, input int exp, input string tag);
        int n = 0;
        do begin
            @(posedge clk); n++; @(negedge clk);
        end while (!tk(v) && n < 100000);
        chk(n == exp, tag, n, exp);
        @(negedge clk);
        chk(!tk(v), "R10 strobe single cycle", int'(tk(v)), 0);
    endtask

    task automatic period_chk(input int v, input int exp, input string tag);
        int n = 0;
        while (!tk(v)) @(negedge clk);
        do begin
            @(negedge clk); n++;
        end while (!tk(v) && n < 100000);
        chk(n == exp, tag, n, exp);
    endtask

    task automatic silent_chk(input int v, input int cycles, input string tag);
        int seen = 0;
        repeat (cycles) begin
            @(negedge clk);
            if (tk(v)) seen++;
        end
        chk(seen == 0, {tag, " no strobe"}, seen, 0);
        if (v == 0) chk(taps_f == '0, {tag, " taps zero"}, int'(taps_f), 0);
        else        chk(taps_x == '0, {tag, " taps zero"}, int'(taps_x), 0);
    endtask

    initial begin
        int t0;
        repeat (3) @(negedge clk);
        chk(tick_f == 1'b0 && taps_f == '0, "R1 reset full", int'(taps_f), 0);
        chk(tick_x == 1'b0 && taps_x == '0, "R1 reset xtal", int'(taps_x), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tick_f == 1'b0 && taps_f == '0, "R1 after reset", int'(taps_f), 0);

        silent_chk(0, 40, "R5 code 111");

        // R9 / R2: start from park with code 000
        code_f = 3'b000;
        latency_chk(0, 4 + (1 << (FLEN - 1)), "R9 first strobe code 000");
        period_chk(0, 1 << FLEN, "R2 period code 000");

        // R12 / R3: switch between running codes
        @(negedge clk);
        code_f = 3'b001;
        latency_chk(0, 4 + (1 << (FLEN - SMID - 1)), "R12 restart on code 001");
        period_chk(0, 1 << (FLEN - SMID), "R3 period code 001");

        // R4 with restart
        @(negedge clk);
        code_f = 3'b010;
        latency_chk(0, 4 + (1 << (FLEN - SXT - 1)), "R12 restart on code 010");
        period_chk(0, 1 << (FLEN - SXT), "R4 period code 010");
        repeat (5) @(negedge clk);
        chk((int'(taps_f) % (1 << SXT)) == 0, "R13 skipped bits zero", int'(taps_f) % (1 << SXT), 0);

        // R11: code takes effect at the third edge
        t0 = int'(taps_f);
        code_f = 3'b111;
        @(negedge clk);
        chk(int'(taps_f) == (t0 + (1 << SXT)) % (1 << FLEN), "R11 edge 1 unchanged",
            int'(taps_f), (t0 + (1 << SXT)) % (1 << FLEN));
        @(negedge clk);
        chk(int'(taps_f) == (t0 + 2 * (1 << SXT)) % (1 << FLEN), "R11 edge 2 unchanged",
            int'(taps_f), (t0 + 2 * (1 << SXT)) % (1 << FLEN));
        @(negedge clk);
        chk(taps_f == '0, "R11 edge 3 parked", int'(taps_f), 0);

        // R6: test-only codes behave as park
        code_f = 3'b010; repeat (10) @(negedge clk);
        code_f = 3'b011; silent_chk(0, 100, "R6 code 011");
        code_f = 3'b000; repeat (10) @(negedge clk);
        code_f = 3'b100; silent_chk(0, 100, "R6 code 100");
        code_f = 3'b001; repeat (10) @(negedge clk);
        code_f = 3'b101; silent_chk(0, 100, "R6 code 101");
        code_f = 3'b010; repeat (10) @(negedge clk);
        code_f = 3'b110; silent_chk(0, 100, "R5 code 110");

        // crystal-only variant
        silent_chk(1, 20, "R8 code 111");
        code_x = 3'b000;
        latency_chk(1, 4 + (1 << (XLEN - 1)), "R9 xtal first strobe");
        period_chk(1, 1 << XLEN, "R7 xtal period code 000");
        code_x = 3'b110;
        period_chk(1, 1 << XLEN, "R7 xtal period code 110");
        period_chk(1, 1 << XLEN, "R7 xtal upper bits no restart");
        code_x = 3'b001; silent_chk(1, 200, "R8 xtal code 001");
        code_x = 3'b011; silent_chk(1, 200, "R8 xtal code 011");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        #(1_000_000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule